// File: doc/BRIEF.md
# Dead-Zone Skew Up/Down Detector

This block decides, for one clock tuning zone, whether the zone's tunable delay must grow, shrink or stay where it is. The skew between the reference clock edge and two leaf points of the zone (left and right) arrives already digitized as signed integers in picosecond units. On each evaluation strobe the block combines the two readings into one effective skew and compares it against a symmetric dead zone around zero. It then raises a one-cycle request to increase or decrease the delay, or reports that the zone is locked.

The half-width of the dead zone follows from the tuning step. The step is the tuning range divided by one less than the number of control bits. The threshold is one and a half steps, so one correction step can never push the skew across to the opposite side of the band. Both the range and the bit count are elaboration-time parameters. The threshold is kept at twice its value so that the factor 1.5 stays exact in integer arithmetic. Each evaluation also produces a one-cycle `decision_valid` pulse that the downstream thermometer code generator uses to accept the decision.

Top module: `skew_updn_detect`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `req_up`, `req_down`, `locked` and `decision_valid` are all 0.
- R2: The threshold is 3*STEP/2, where STEP = TUNE_RANGE_PS/(CTRL_BITS-1) uses integer division. With the defaults (60 ps, 4 bits) STEP is 20 and the threshold is 30 ps.
- R3: The effective skew is floor((skew_left + skew_right)/2), rounded toward minus infinity, so (-30,-31) gives -31 and (30,31) gives 30.
- R4: An evaluation whose effective skew is strictly greater than +threshold drives `req_down`=1, `req_up`=0 and `locked`=0.
- R5: An evaluation whose effective skew is strictly less than -threshold drives `req_up`=1, `req_down`=0 and `locked`=0.
- R6: An evaluation whose effective skew lies within [-threshold, +threshold], bounds included, drives `locked`=1 with neither request.
- R7: `req_up` and `req_down` are never 1 in the same cycle, and neither is 1 while `locked` is 1.
- R8: Outputs change on the clock edge that samples `sample_valid`=1, so results are visible one cycle after the strobe. In any cycle that follows a cycle without a strobe, `req_up`, `req_down` and `decision_valid` are 0.
- R9: `locked` keeps its value between strobes. It stays 1 across consecutive in-band evaluations and falls on the first out-of-band one.
- R10: `decision_valid` is 1 for exactly the cycle after each strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | Evaluation strobe; skew inputs are valid this cycle |
| skew_left | input | SKEW_W | Signed skew at the left leaf, ps |
| skew_right | input | SKEW_W | Signed skew at the right leaf, ps |
| req_up | output | 1 | One-cycle request to increase the zone delay |
| req_down | output | 1 | One-cycle request to decrease the zone delay |
| locked | output | 1 | Last evaluation was inside the dead zone |
| decision_valid | output | 1 | One-cycle pulse marking a fresh decision |

## Verification
The hardest cases to reach are those at the exact edges of the band, where the floor in the averaging decides the result. The stimulus places leaf pairs at ±30, ±31 and at odd sums such as (30,31) and (-30,-31). These show that rounding toward minus infinity makes a negative odd sum fall out of the band while the mirrored positive sum stays locked. Leaf pairs that diverge widely but average into the band, and idle cycles between strobes, check that the lock flag holds and that requests never linger.

// File: rtl/skew_updn_detect.sv
module skew_updn_detect #(
  parameter int TUNE_RANGE_PS = 60,
  parameter int CTRL_BITS     = 4,
  parameter int SKEW_W        = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic signed [SKEW_W-1:0] skew_left,
  input  logic signed [SKEW_W-1:0] skew_right,
  output logic                     req_up,
  output logic                     req_down,
  output logic                     locked,
  output logic                     decision_valid
);

  localparam int STEP_PS = TUNE_RANGE_PS / (CTRL_BITS - 1);
  localparam int THR_X2  = 3 * STEP_PS;
  localparam logic signed [SKEW_W+1:0] LIM_X2 = THR_X2[SKEW_W+1:0];

  logic signed [SKEW_W:0]   pair_sum;
  logic signed [SKEW_W+1:0] eff_x2;
  logic                     too_late, too_early;

  assign pair_sum  = SKEW_W'(skew_left) + SKEW_W'(skew_right) + (SKEW_W+1)'(0);
  assign eff_x2    = {pair_sum[SKEW_W], pair_sum[SKEW_W:1], 1'b0};
  assign too_late  = eff_x2 > LIM_X2;
  assign too_early = eff_x2 < -LIM_X2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_up         <= 1'b0;
      req_down       <= 1'b0;
      locked         <= 1'b0;
      decision_valid <= 1'b0;
    end else begin
      decision_valid <= sample_valid;
      req_up         <= sample_valid && too_early;
      req_down       <= sample_valid && too_late;
      if (sample_valid) locked <= !too_late && !too_early;
    end
  end

  p_req_mutex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_up && req_down));
  p_lock_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !(req_up || req_down));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !(req_up || req_down || decision_valid));
  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> $stable(locked));
  p_dv_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> decision_valid);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> $countones({req_up, req_down, locked}) == 1);

endmodule

// File: tb/skew_updn_detect_tb.sv
module skew_updn_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_valid = 1'b0;
  logic signed [9:0] skew_left = '0, skew_right = '0;
  logic req_up, req_down, locked, decision_valid;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  skew_updn_detect u_dut (.clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .skew_left(skew_left), .skew_right(skew_right), .req_up(req_up),
    .req_down(req_down), .locked(locked), .decision_valid(decision_valid));

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {up,dn,lk,dv} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic eval(input int l, input int r, input bit up, input bit dn, input bit lk,
                      input string req);
    @(negedge clk);
    skew_left = 10'(l); skew_right = 10'(r); sample_valid = 1'b1;
    @(posedge clk); #1;
    check(req, {req_up, req_down, locked, decision_valid}, {up, dn, lk, 1'b1});
    @(negedge clk);
    sample_valid = 1'b0; skew_left = 10'sd200; skew_right = 10'sd200;
    @(posedge clk); #1;
    check({req, " idle R8 R9"}, {req_up, req_down, locked, decision_valid}, {2'b00, lk, 1'b0});
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", {req_up, req_down, locked, decision_valid}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after release", {req_up, req_down, locked, decision_valid}, 4'b0000);
  endtask

  task automatic t_band_edges;
    eval(0, 0, 0, 0, 1, "R6 zero");
    eval(30, 30, 0, 0, 1, "R2 R6 upper bound");
    eval(31, 31, 0, 1, 0, "R4 above bound");
    eval(-30, -30, 0, 0, 1, "R6 lower bound");
    eval(-31, -31, 1, 0, 0, "R5 below bound");
  endtask

  task automatic t_rounding;
    eval(30, 31, 0, 0, 1, "R3 positive odd sum floors in");
    eval(-30, -31, 1, 0, 0, "R3 negative odd sum floors out");
    eval(100, -100, 0, 0, 1, "R3 split leaves average zero");
    eval(-200, 260, 0, 0, 1, "R3 wide split avg 30");
    eval(-250, 100, 1, 0, 0, "R3 R5 wide split avg -75");
    eval(255, 200, 0, 1, 0, "R4 large positive");
  endtask

  task automatic t_lock_sequence;
    eval(5, -5, 0, 0, 1, "R9 lock first");
    eval(-12, 20, 0, 0, 1, "R9 lock held");
    eval(40, 40, 0, 1, 0, "R9 lock drops");
    eval(-1, 0, 0, 0, 1, "R9 relock");
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    sample_valid = 1'b1; skew_left = 10'sd50; skew_right = 10'sd50;
    @(posedge clk); #1;
    check("R10 first strobe", {req_up, req_down, locked, decision_valid}, 4'b0101);
    @(negedge clk);
    skew_left = -10'sd50; skew_right = -10'sd50;
    @(posedge clk); #1;
    check("R7 R10 second strobe", {req_up, req_down, locked, decision_valid}, 4'b1001);
    @(negedge clk);
    sample_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 after burst", {req_up, req_down, locked, decision_valid}, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_band_edges();
    t_rounding();
    t_lock_sequence();
    t_back_to_back();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule